// File: doc/BRIEF.md
# Dithered Two-Phase Switch Sequencer

This block produces the two switch-control enables for a switched-capacitor charge pump: a charge phase followed by a transfer phase, repeating without end while enabled. The length of each phase is not fixed. It is chosen by a 16-bit maximal-length linear feedback shift register. This spreads the switching energy over many frequencies, so the pump emits less interference at any single tone and is harder for an outside tone to disturb. The two enables are never on together. At least one all-off cycle always separates them. A one-cycle strobe marks the first cycle of every transfer phase, so that a downstream half-rate sampling stage can align its check with it.

The register is loaded from a seed input during synchronous reset. While enable is low, both enables stay off and the register does not move. When enable returns, the sequence resumes exactly where it stopped, always starting with a charge phase.

Top module: `dither_phase_gen`

## Requirements
- R1: While reset is high, both phase enables and the strobe are low, and the shift register is loaded from the seed input.
- R2: The charge enable and the transfer enable are never high in the same cycle.
- R3: Phases alternate strictly as charge, then transfer, then charge. The first phase after enable rises, or after reset is released with enable high, is a charge phase.
- R4: Exactly GAP_CYC all-off cycles (default 1) follow each charge phase, and exactly GAP_CYC follow each transfer phase.
- R5: The register holds a value s. It shifts left with the new bit 0 equal to s[15]^s[14]^s[12]^s[3], which is the tap set 16,15,13,4. It advances exactly once at the start of each phase. The phase that starts lasts 1 + s[0] cycles, where s[0] is bit 0 of the register before that advance.
- R6: An all-zero seed is replaced by 16'hACE1.
- R7: The strobe is high for exactly one cycle, the first cycle of each transfer phase, and at no other time.
- R8: In the cycle after enable is seen low, both enables and the strobe are low, and they stay low while enable stays low. The register does not advance during that time. On re-enable the sequence continues from the frozen register value with a new charge phase.
- R9: Changes on the seed input outside reset have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds both phases off and freezes the sequence |
| seed | input | 16 | Shift register start value, sampled only in reset |
| ph_charge | output | 1 | Charge-phase switch enable |
| ph_xfer | output | 1 | Transfer-phase switch enable |
| xfer_start | output | 1 | One-cycle strobe on the first cycle of each transfer phase |

## Verification
The case that is hardest to reach from the ports is a disable that lands in the middle of a two-cycle phase. There the register has already advanced for a phase that never completes, and the re-enable must start a fresh charge phase from that advanced value. The stimulus reaches this case by walking a bench-side copy of the shift sequence to find where the phases lie. It drops enable one cycle into a charge phase and, separately, one cycle into a transfer phase. It then checks every following cycle against the sequence continued from that point. Long runs from several seeds, including a zero seed and a seed changed in mid-run, cover both phase lengths many times in every position.

// File: rtl/dither_phase_pkg.sv
package dither_phase_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CHARGE = 3'd1,
      ST_GAP_A  = 3'd2,
      ST_XFER   = 3'd3,
      ST_GAP_B  = 3'd4
   } phase_st_t;

endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
   parameter int unsigned            W        = 16,
   parameter logic [W-1:0]           TAP_MASK = 16'hD008,
   parameter logic [W-1:0]           ALT_SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);

   initial begin
      if (W < 4) $error("dither_lfsr: W must be at least 4");
      if (!TAP_MASK[W-1]) $error("dither_lfsr: top tap must be set");
      if (ALT_SEED == '0) $error("dither_lfsr: ALT_SEED must be nonzero");
   end

   logic [W-1:0] fb_chain;

   generate
      for (genvar i = 0; i < W; i++) begin : g_tap
         if (i == 0) begin : g_first
            assign fb_chain[i] = TAP_MASK[i] & state[i];
         end else begin : g_next
            assign fb_chain[i] = fb_chain[i-1] ^ (TAP_MASK[i] & state[i]);
         end
      end
   endgenerate

   logic [W-1:0] seed_fix;
   assign seed_fix = (seed == '0) ? ALT_SEED : seed;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= seed_fix;
      end else if (adv) begin
         state <= {state[W-2:0], fb_chain[W-1]};
      end
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state != '0);  // R6

   AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!$past(adv) && !$past(rst)) |-> $stable(state));  // R8

endmodule

// File: rtl/dither_step_fsm.sv
module dither_step_fsm
   import dither_phase_pkg::*;
#(
   parameter int unsigned GAP_CYC = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic len_bit,
   output logic adv,
   output logic ph_charge,
   output logic ph_xfer,
   output logic xfer_start
);

   localparam int unsigned CNT_W   = $clog2(GAP_CYC + 2);
   localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

   initial begin
      if (GAP_CYC < 1) $error("dither_step_fsm: GAP_CYC must be at least 1");
   end

   phase_st_t        st;
   logic [CNT_W-1:0] cnt;
   logic             stb_q;
   logic             last;

   assign last = (cnt == '0);

   always_comb begin
      adv = 1'b0;
      if (en) begin
         unique case (st)
            ST_IDLE:  adv = 1'b1;
            ST_GAP_A: adv = last;
            ST_GAP_B: adv = last;
            default:  adv = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= (st == ST_GAP_A) && last;
         unique case (st)
            ST_IDLE: begin
               st  <= ST_CHARGE;
               cnt <= {{(CNT_W-1){1'b0}}, len_bit};
            end
            ST_CHARGE: begin
               if (last) begin
                  st  <= ST_GAP_A;
                  cnt <= GAP_LOAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP_A: begin
               if (last) begin
                  st  <= ST_XFER;
                  cnt <= {{(CNT_W-1){1'b0}}, len_bit};
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_XFER: begin
               if (last) begin
                  st  <= ST_GAP_B;
                  cnt <= GAP_LOAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP_B: begin
               if (last) begin
                  st  <= ST_CHARGE;
                  cnt <= {{(CNT_W-1){1'b0}}, len_bit};
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               st  <= ST_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end

   assign ph_charge  = (st == ST_CHARGE);
   assign ph_xfer    = (st == ST_XFER);
   assign xfer_start = stb_q;

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      !(ph_charge && ph_xfer));  // R2

   AST_GAP_AFTER_CHARGE: assert property (@(posedge clk) disable iff (rst)
      $fell(ph_charge) |-> !ph_xfer);  // R4

   AST_GAP_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
      $fell(ph_xfer) |-> !ph_charge);  // R4

   AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (rst)
      xfer_start |-> (ph_xfer && !$past(ph_xfer)));  // R7

   AST_STROBE_COVER: assert property (@(posedge clk) disable iff (rst)
      $rose(ph_xfer) |-> xfer_start);  // R7

   AST_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
      (ph_charge && $past(ph_charge)) |=> !ph_charge);  // R5

   AST_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
      !$past(en) |-> (!ph_charge && !ph_xfer && !xfer_start));  // R8

endmodule

// File: rtl/dither_phase_gen.sv
module dither_phase_gen #(
   parameter int unsigned            SEQ_W    = 16,
   parameter logic [SEQ_W-1:0]       TAP_MASK = 16'hD008,
   parameter logic [SEQ_W-1:0]       ALT_SEED = 16'hACE1,
   parameter int unsigned            GAP_CYC  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [SEQ_W-1:0] seed,
   output logic             ph_charge,
   output logic             ph_xfer,
   output logic             xfer_start
);

   logic             adv;
   logic [SEQ_W-1:0] seq_state;

   dither_lfsr #(
      .W        (SEQ_W),
      .TAP_MASK (TAP_MASK),
      .ALT_SEED (ALT_SEED)
   ) i_lfsr (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .seed  (seed),
      .state (seq_state)
   );

   dither_step_fsm #(
      .GAP_CYC (GAP_CYC)
   ) i_fsm (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .len_bit    (seq_state[0]),
      .adv        (adv),
      .ph_charge  (ph_charge),
      .ph_xfer    (ph_xfer),
      .xfer_start (xfer_start)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!ph_charge && !ph_xfer && !xfer_start));  // R1

endmodule

// File: tb/test_dither_phase_gen.sv
`timescale 1ns/1ps
module test_dither_phase_gen;

   localparam int GAP = 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [15:0] seed = 16'h1234;
   logic        ph_charge, ph_xfer, xfer_start;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   logic [15:0] m;

   always #2.5 clk = ~clk;

   dither_phase_gen i_dither_phase_gen (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .seed       (seed),
      .ph_charge  (ph_charge),
      .ph_xfer    (ph_xfer),
      .xfer_start (xfer_start)
   );

   function automatic logic [15:0] nx(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
   endfunction

   task automatic chk(input logic e1, input logic e2, input logic es, input string req);
      @(negedge clk);
      checks++;
      if ({ph_charge, ph_xfer, xfer_start} !== {e1, e2, es}) begin
         errors++;
         $display("FAIL %s t=%0t actual ch/xf/st=%b%b%b expected=%b%b%b",
                  req, $time, ph_charge, ph_xfer, xfer_start, e1, e2, es);
      end
   endtask

   // kind 1 = charge, 2 = transfer; runs at most maxc cycles of the phase
   task automatic phase(input int kind, input int maxc);
      int d;
      d = 1 + int'(m[0]);
      m = nx(m);
      for (int i = 0; i < d && i < maxc; i++)
         chk(kind == 1, kind == 2, kind == 2 && i == 0, "R3/R5/R7 R2");
   endtask

   task automatic gap();
      for (int i = 0; i < GAP; i++) chk(1'b0, 1'b0, 1'b0, "R4 R2");
   endtask

   task automatic periods(input int n);
      for (int k = 0; k < n; k++) begin
         phase(1, 2); gap();
         phase(2, 2); gap();
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_up();
   end

   initial begin
      // R1: reset holds everything low
      repeat (3) chk(1'b0, 1'b0, 1'b0, "R1");
      @(negedge clk); rst = 1'b0;
      // R8: enable low after reset keeps outputs off
      repeat (3) chk(1'b0, 1'b0, 1'b0, "R8");

      en = 1'b1;
      m  = 16'h1234;
      periods(40);

      // R9: seed changes outside reset are ignored
      seed = 16'hFFFF;
      periods(40);
      seed = 16'h0000;
      periods(10);

      // R8: disable one cycle into a charge phase
      phase(1, 1);
      en = 1'b0;
      repeat (4) chk(1'b0, 1'b0, 1'b0, "R8");
      en = 1'b1;
      periods(10);

      // R8: disable one cycle into a transfer phase
      phase(1, 2); gap();
      phase(2, 1);
      en = 1'b0;
      repeat (3) chk(1'b0, 1'b0, 1'b0, "R8");
      en = 1'b1;
      periods(10);

      // R6: zero seed replaced by the alternate value
      en = 1'b0; rst = 1'b1; seed = 16'h0000;
      repeat (2) chk(1'b0, 1'b0, 1'b0, "R1");
      rst = 1'b0; en = 1'b1;
      m = 16'hACE1;
      periods(60);

      // R1/R3: reset with enable high starts with a charge phase
      rst = 1'b1; seed = 16'hBEEF;
      repeat (2) chk(1'b0, 1'b0, 1'b0, "R1");
      rst = 1'b0;
      m = 16'hBEEF;
      periods(200);

      finish_up();
   end

endmodule